// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Counter

A binary up-counter, four bits wide by default, whose state changes only on the rising clock edge. At each edge it clears, loads a parallel word, counts up by one, or holds. Clearing outranks loading, and loading outranks counting. Counting needs two enables to be high at once. One of them, the trickle enable, also gates the terminal-count output. A carry can therefore ripple through a chain of stages combinationally, while every stage still updates on the same shared clock edge.

Several stages form one wide synchronous counter when they share the clock, the clear, the load strobe and a common parallel enable, and each stage's terminal count drives the next stage's trickle enable. A single stage that reloads on its own terminal count makes a programmable divider. A chip-level asynchronous reset also forces the count to zero. Its release is retimed inside the block, so the block leaves reset on a known clock edge.

Top module: `sync_preset_counter`

## Requirements
- R1: When `clr_n` and `load_n` are high and both `cnt_en_p` and `cnt_en_t` are high, `q` increases by one at the rising edge.
- R2: Counting from the all-ones value (15 for WIDTH=4) wraps `q` to 0 at the rising edge.
- R3: A low `clr_n` at a rising edge sets `q` to 0, whatever the values of `load_n`, `cnt_en_p`, `cnt_en_t` and `din`.
- R4: With `clr_n` high and `load_n` low, the rising edge copies `din` into `q`, whatever the values of the two count enables.
- R5: With `clr_n` and `load_n` high and either count enable low, `q` keeps its value across the edge.
- R6: `tc` is combinational. It is 1 exactly when `cnt_en_t` is 1 and `q` is all ones, and it does not depend on `cnt_en_p`.
- R7: While `rst_n` is low, `q` is 0. After `rst_n` rises, the first two rising edges leave `q` at 0. The third edge is the first one at which the counter can change.
- R8: Two stages sharing the clock and control inputs, with the low stage's `tc` driving the high stage's `cnt_en_t`, behave as a single counter twice as wide. The high stage advances only on the edge where the low stage wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release retimed internally |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_p | input | 1 | Count enable shared across a chain |
| cnt_en_t | input | 1 | Count enable that also gates `tc` |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal count: all ones and `cnt_en_t` high |

## Verification
The bench tries clear together with load and both enables, load with both enables low, and `cnt_en_p` low at the all-ones value. A design with the priority wrong would load or count when it should clear. A design that gated the terminal count with the wrong enable would drop `tc` when `cnt_en_p` falls. It also drives a two-stage chain through the 15-to-0 boundary. A stage that latched its carry, or that let the high stage count off `cnt_en_p` alone, would advance the upper nibble on the wrong edge. Reset release is checked edge by edge, because a missing retiming stage would let the count move one edge early.

// File: rtl/spc_pkg.sv
package spc_pkg;
  // Action selected for the coming rising edge, highest priority last listed.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } spc_act_e;
endpackage

// File: rtl/spc_rst_sync.sv
module spc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;

  // R7: asynchronous assertion, release after STAGES rising edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
(
  input  logic     clr_n,
  input  logic     load_n,
  input  logic     cnt_en_p,
  input  logic     cnt_en_t,
  output spc_act_e act
);
  // Priority: clear (R3), load (R4), count (R1), hold (R5)
  always_comb begin
    if (!clr_n)                    act = ACT_CLEAR;
    else if (!load_n)              act = ACT_LOAD;
    else if (cnt_en_p && cnt_en_t) act = ACT_COUNT;
    else                           act = ACT_HOLD;
  end
endmodule

// File: rtl/spc_next.sv
module spc_next
  import spc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  spc_act_e         act,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt,
  output logic             upd
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    nxt = cur;
    upd = 1'b1;
    unique case (act)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = din;
      ACT_COUNT: nxt = cur + ONE;   // R2: natural wrap modulo 2**WIDTH
      default:   upd = 1'b0;
    endcase
  end
endmodule

// File: rtl/spc_reg.sv
module spc_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/spc_tc.sv
module spc_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic             en_t,
  output logic             tc
);
  // R6: carry out gated only by the trickle enable
  assign tc = en_t & (&cnt);
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import spc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             cnt_en_p,
  input  logic             cnt_en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  logic             rst_sync_n;
  spc_act_e         act;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_upd;

  spc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  spc_ctrl u_ctrl (
    .clr_n(clr_n), .load_n(load_n), .cnt_en_p(cnt_en_p),
    .cnt_en_t(cnt_en_t), .act(act)
  );

  spc_next #(.WIDTH(WIDTH)) u_next (
    .act(act), .cur(cnt_q), .din(din), .nxt(cnt_d), .upd(cnt_upd)
  );

  spc_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .en(cnt_upd), .d(cnt_d), .q(cnt_q)
  );

  spc_tc #(.WIDTH(WIDTH)) u_tc (
    .cnt(cnt_q), .en_t(cnt_en_t), .tc(tc)
  );

  assign q = cnt_q;
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             clr_n,
  input logic             load_n,
  input logic             cnt_en_p,
  input logic             cnt_en_t,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             tc
);
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_ok)
    (clr_n && load_n && cnt_en_p && cnt_en_t) |=> (q == WIDTH'($past(q) + 1'b1))); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    (clr_n && load_n && cnt_en_p && cnt_en_t && (&q)) |=> (q == '0)); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_ok)
    !clr_n |=> (q == '0)); // R3
  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_ok)
    (clr_n && !load_n) |=> (q == $past(din))); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    (clr_n && load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(q)); // R5
  AST_TC_GATED: assert property (@(posedge clk) disable iff (!rst_ok)
    !cnt_en_t |-> !tc); // R6
  AST_TC_AT_MAX: assert property (@(posedge clk) disable iff (!rst_ok)
    tc |-> (&q)); // R6
endmodule

bind sync_preset_counter spc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .clr_n(clr_n), .load_n(load_n),
  .cnt_en_p(cnt_en_p), .cnt_en_t(cnt_en_t), .din(din), .q(q), .tc(tc)
);

// File: tb/sync_preset_counter_tb.sv
module sync_preset_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int MAXV       = (1 << W) - 1;
  localparam int WATCHDOG   = 5000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr_n, load_n, en_p, en_t;
  logic [W-1:0] din_lo, din_hi;
  logic [W-1:0] q_lo, q_hi;
  logic         tc_lo, tc_hi;

  int checks = 0;
  int errors = 0;
  int m_lo   = 0;
  int m_hi   = 0;
  string tag_lo = "R7";
  string tag_hi = "R7";

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_preset_counter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .cnt_en_p(en_p), .cnt_en_t(en_t), .din(din_lo), .q(q_lo), .tc(tc_lo)
  );

  // Upper stage of the R8 cascade
  sync_preset_counter #(.WIDTH(W)) u_hi (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .load_n(load_n),
    .cnt_en_p(en_p), .cnt_en_t(tc_lo), .din(din_hi), .q(q_hi), .tc(tc_hi)
  );

  function automatic int model_next(int cur, bit c, bit l, bit p, bit t, int d);
    if (!c)          return 0;
    else if (!l)     return d;
    else if (p && t) return (cur + 1) & MAXV;
    else             return cur;
  endfunction

  function automatic string model_tag(int cur, bit c, bit l, bit p, bit t);
    if (!c)          return "R3";
    else if (!l)     return "R4";
    else if (p && t) return (cur == MAXV) ? "R2" : "R1";
    else             return "R5";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic cycle(bit c, bit l, bit p, bit t, int dl, int dh);
    bit tl, th;
    int nl, nh;
    check(tag_lo, "q_lo", int'(q_lo), m_lo);
    check(tag_hi == "R7" ? "R7" : "R8", "q_hi", int'(q_hi), m_hi);
    clr_n = c; load_n = l; en_p = p; en_t = t;
    din_lo = W'(dl); din_hi = W'(dh);
    #1;
    tl = t && (m_lo == MAXV);
    th = tl && (m_hi == MAXV);
    check("R6", "tc_lo", int'(tc_lo), int'(tl));
    check("R8", "tc_hi", int'(tc_hi), int'(th));
    nl = model_next(m_lo, c, l, p, t, dl);
    nh = model_next(m_hi, c, l, p, tl, dh);
    tag_lo = model_tag(m_lo, c, l, p, t);
    tag_hi = "R8";
    @(posedge clk);
    m_lo = nl;
    m_hi = nh;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected<%0d cycles", WATCHDOG, WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clr_n = 1'b1; load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    din_lo = '0; din_hi = '0;
    #3;
    check("R7", "q_lo in reset", int'(q_lo), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", "q_lo in reset", int'(q_lo), 0);
    check("R7", "q_hi in reset", int'(q_hi), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7", "q_lo two edges after release", int'(q_lo), 0);
    // third edge counts: lo 0 -> 1
    cycle(1, 1, 1, 1, 0, 0);
    tag_lo = "R7";
    check("R7", "q_lo first count after release", int'(q_lo), 1);

    // R4: load with both enables low
    cycle(1, 0, 0, 0, MAXV, MAXV - 1);
    // R6/R5: cnt_en_p low at all-ones, tc still high, count holds
    cycle(1, 1, 0, 1, 3, 3);
    cycle(1, 1, 0, 1, 3, 3);
    // R2/R8: wrap of low stage carries into high stage
    cycle(1, 1, 1, 1, 0, 0);
    check("R2", "q_lo after wrap", int'(q_lo), 0);
    check("R8", "q_hi after carry", int'(q_hi), MAXV);
    // R1: run a full low-stage period, chain wraps to zero
    for (int k = 0; k < MAXV + 1; k++) cycle(1, 1, 1, 1, 0, 0);
    check("R8", "q_hi after full chain wrap", int'(q_hi), 0);
    // R5: trickle enable low holds both stages
    cycle(1, 0, 1, 1, 9, 6);
    cycle(1, 1, 1, 0, 0, 0);
    // R3: clear beats load and count
    cycle(0, 0, 1, 1, 5, 5);
    cycle(1, 1, 1, 1, 0, 0);
    check("R3", "q_lo after clear then count", int'(q_lo), 1);

    for (int k = 0; k < 600; k++) begin
      bit c, l, p, t;
      c = ($urandom_range(15) != 0);
      l = ($urandom_range(7) != 0);
      p = ($urandom_range(3) != 0);
      t = ($urandom_range(3) != 0);
      cycle(c, l, p, t, int'($urandom_range(MAXV)), int'($urandom_range(MAXV)));
    end
    cycle(1, 1, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule